// File: doc/BRIEF.md
# Decimal-Capable 8-bit ALU

This block is the arithmetic and logic unit of an accumulator-based 8-bit processor. It is purely combinational. The sequencer supplies an operation code, the accumulator, a memory operand, the current carry and the decimal-mode bit. The block returns an 8-bit result and the sign (N), overflow (V), zero (Z) and carry (C) flags. Each of these outputs has its own write-enable, so the surrounding status register and accumulator take only what the operation defines. Register storage, sequencing and the status register itself live outside this block.

Add and subtract always take the incoming carry. When decimal mode is set they work on packed BCD digits. Increment, decrement and compare reuse the same adder and always run in binary. Single-operand operations (shifts, rotates, increment, decrement) act on the memory operand port. The sequencer routes the accumulator there when the accumulator is the target.

Top module: `alu8_dec`

## Requirements
- R1: Op codes 0 (AND), 1 (exclusive OR) and 2 (inclusive OR) combine `acc` and `opnd` bitwise into `result`. They assert `res_we`, `we_n` and `we_z`, and leave `we_v` and `we_c` low.
- R2: Op code 3 (bit test) deasserts `res_we` and `we_c`, and asserts `we_n`, `we_v` and `we_z`. It sets Z when `acc & opnd` is zero, V to `opnd[6]` and N to `opnd[7]`.
- R3: Op code 4 shifts `opnd` left with a zero into bit 0 and bit 7 into C. Op code 5 shifts right with a zero into bit 7 and bit 0 into C. Both write result, N, Z and C.
- R4: Op code 6 rotates `opnd` left, moving `carry_in` into bit 0 and bit 7 into C. Op code 7 rotates right, moving `carry_in` into bit 7 and bit 0 into C. Both write result, N, Z and C.
- R5: Op code 8 with `dec_mode` low gives `acc + opnd + carry_in`, with C equal to the carry out. V is set when both adder inputs share a sign and the 8-bit sum has the other sign. It writes result, N, V, Z and C.
- R6: Op code 9 with `dec_mode` low gives `acc + ~opnd + carry_in`. C high means no borrow. V uses the R5 rule with `~opnd` as the second input. It writes result, N, V, Z and C.
- R7: Op code 8 with `dec_mode` high adds valid packed-BCD operands plus `carry_in` as two decimal digits. For example, 0x09 + 0x01 gives 0x10, and 0x99 + 0x01 gives 0x00 with C=1. V keeps the binary R5 rule on the uncorrected inputs.
- R8: Op code 9 with `dec_mode` high subtracts packed-BCD `opnd` and the borrow (`!carry_in`) from `acc`. For example, 0x10 - 0x01 gives 0x09 with C=1, and 0x00 - 0x01 gives 0x99 with C=0. V keeps the binary R6 rule.
- R9: Op code 10 gives `opnd + 1` and op code 11 gives `opnd - 1`, modulo 256 and binary even in decimal mode. They write result, N and Z only.
- R10: Op code 12 compares `acc` with `opnd` in binary regardless of `dec_mode`. C is high when `acc >= opnd`, and N and Z come from the 8-bit difference. Only `we_n`, `we_z` and `we_c` are high; `res_we` and `we_v` are low.
- R11: For every operation other than op code 3 that writes N or Z, N equals bit 7 of `result` and Z is high exactly when `result` is zero.
- R12: Op codes 13 to 15 assert no write-enable at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code (0 to 12 defined) |
| acc | input | 8 | Accumulator value |
| opnd | input | 8 | Memory operand, or target of single-operand operations |
| carry_in | input | 1 | Current carry flag |
| dec_mode | input | 1 | Decimal mode for add and subtract |
| result | output | 8 | Operation result |
| res_we | output | 1 | Result should be written back |
| flag_n | output | 1 | Sign flag value |
| flag_v | output | 1 | Overflow flag value |
| flag_z | output | 1 | Zero flag value |
| flag_c | output | 1 | Carry flag value |
| we_n | output | 1 | Sign flag write-enable |
| we_v | output | 1 | Overflow flag write-enable |
| we_z | output | 1 | Zero flag write-enable |
| we_c | output | 1 | Carry flag write-enable |

## Verification
Every output of this block is due in the same cycle as its inputs, since there is no register between ports. The driver applies a vector just after a rising edge and queues its expected value. The monitor pops and compares at the following falling edge, half a period later, once the adder and decimal-correction chain have settled. Only one vector is in flight per cycle, so the queue order alone pairs each stimulus with its result.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'd0,
    OP_EOR = 4'd1,
    OP_ORA = 4'd2,
    OP_BIT = 4'd3,
    OP_ASL = 4'd4,
    OP_LSR = 4'd5,
    OP_ROL = 4'd6,
    OP_ROR = 4'd7,
    OP_ADC = 4'd8,
    OP_SBC = 4'd9,
    OP_INC = 4'd10,
    OP_DEC = 4'd11,
    OP_CMP = 4'd12
  } alu_op_e;

endpackage

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          lg_op,
  input  logic [WIDTH-1:0] lg_a,
  input  logic [WIDTH-1:0] lg_m,
  output logic [WIDTH-1:0] lg_res,
  output logic             tst_n,
  output logic             tst_v,
  output logic             tst_z
);

  logic [WIDTH-1:0] masked;

  assign masked = lg_a & lg_m;

  always_comb begin
    case (lg_op)
      OP_EOR:  lg_res = lg_a ^ lg_m;
      OP_ORA:  lg_res = lg_a | lg_m;
      default: lg_res = masked;
    endcase
  end

  // bit test: flags only
  assign tst_z = (masked == '0);
  assign tst_v = lg_m[WIDTH-2];
  assign tst_n = lg_m[WIDTH-1];

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          sh_op,
  input  logic [WIDTH-1:0] sh_in,
  input  logic             sh_cin,
  output logic [WIDTH-1:0] sh_res,
  output logic             sh_cout
);

  logic fill_lo;
  logic fill_hi;

  // rotates feed the old carry in; plain shifts feed zero
  assign fill_lo = (sh_op == OP_ROL) ? sh_cin : 1'b0;
  assign fill_hi = (sh_op == OP_ROR) ? sh_cin : 1'b0;

  always_comb begin
    case (sh_op)
      OP_LSR, OP_ROR: begin
        sh_res  = {fill_hi, sh_in[WIDTH-1:1]};
        sh_cout = sh_in[0];
      end
      default: begin
        sh_res  = {sh_in[WIDTH-2:0], fill_lo};
        sh_cout = sh_in[WIDTH-1];
      end
    endcase
  end

endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int WIDTH      = 8,
  parameter bit DECIMAL_EN = 1'b1
) (
  input  logic [WIDTH-1:0] add_a,
  input  logic [WIDTH-1:0] add_b,
  input  logic             add_cin,
  input  logic             add_dec,
  input  logic             add_sub,
  output logic [WIDTH-1:0] add_sum,
  output logic             add_cout,
  output logic             add_ovf
);

  localparam int NIB = WIDTH / 4;

  // Digit-serial decimal chain. add_b is already complemented for a subtract.
  // Add: a digit sum above 9 gets +6 and carries.
  // Subtract: a digit with no carry out (a borrow) gets -6.
  function automatic logic [WIDTH:0] bcd_chain(
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic             sub
  );
    logic             c;
    logic [4:0]       s;
    logic [WIDTH-1:0] r;
    c = cin;
    r = '0;
    for (int i = 0; i < NIB; i++) begin
      s = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0, c};
      if (!sub) begin
        if (s > 5'd9) begin
          s = s + 5'd6;
          c = 1'b1;
        end else begin
          c = 1'b0;
        end
      end else begin
        c = s[4];
        if (!c) s = s - 5'd6;
      end
      r[4*i +: 4] = s[3:0];
    end
    return {c, r};
  endfunction

  logic [WIDTH:0] bin_full;

  assign bin_full = {1'b0, add_a} + {1'b0, add_b} + {{WIDTH{1'b0}}, add_cin};
  assign add_ovf  = (add_a[WIDTH-1] == add_b[WIDTH-1]) &&
                    (bin_full[WIDTH-1] != add_a[WIDTH-1]);

  generate
    if (DECIMAL_EN) begin : g_dec
      logic [WIDTH:0] dec_full;
      always_comb dec_full = bcd_chain(add_a, add_b, add_cin, add_sub);
      assign {add_cout, add_sum} = add_dec ? dec_full : bin_full;
    end else begin : g_bin
      assign {add_cout, add_sum} = bin_full;
    end
  endgenerate

endmodule

// File: rtl/alu8_dec.sv
module alu8_dec
  import alu8_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter bit DECIMAL_EN = 1'b1
) (
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] opnd,
  input  logic             carry_in,
  input  logic             dec_mode,
  output logic [WIDTH-1:0] result,
  output logic             res_we,
  output logic             flag_n,
  output logic             flag_v,
  output logic             flag_z,
  output logic             flag_c,
  output logic             we_n,
  output logic             we_v,
  output logic             we_z,
  output logic             we_c
);

  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  // operation class decode, named for the checker
  logic is_logic, is_bit, is_shift, is_arith, is_step, is_cmp, known_op;

  assign is_logic = (op_e == OP_AND) || (op_e == OP_EOR) || (op_e == OP_ORA);
  assign is_bit   = (op_e == OP_BIT);
  assign is_shift = (op_e == OP_ASL) || (op_e == OP_LSR) ||
                    (op_e == OP_ROL) || (op_e == OP_ROR);
  assign is_arith = (op_e == OP_ADC) || (op_e == OP_SBC);
  assign is_step  = (op_e == OP_INC) || (op_e == OP_DEC);
  assign is_cmp   = (op_e == OP_CMP);
  assign known_op = is_logic | is_bit | is_shift | is_arith | is_step | is_cmp;

  // logic unit
  logic [WIDTH-1:0] lg_res;
  logic             tst_n, tst_v, tst_z;

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .lg_op (op_e),
    .lg_a  (acc),
    .lg_m  (opnd),
    .lg_res(lg_res),
    .tst_n (tst_n),
    .tst_v (tst_v),
    .tst_z (tst_z)
  );

  // shifter
  logic [WIDTH-1:0] sh_res;
  logic             sh_cout;

  alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .sh_op  (op_e),
    .sh_in  (opnd),
    .sh_cin (carry_in),
    .sh_res (sh_res),
    .sh_cout(sh_cout)
  );

  // shared adder operand steering
  logic [WIDTH-1:0] add_a, add_b, add_sum;
  logic             add_cin, add_dec, add_sub, add_cout, add_ovf;

  always_comb begin
    add_a   = acc;
    add_b   = opnd;
    add_cin = carry_in;
    add_dec = 1'b0;
    add_sub = 1'b0;
    case (op_e)
      OP_ADC: add_dec = dec_mode;
      OP_SBC: begin
        add_b   = ~opnd;
        add_dec = dec_mode;
        add_sub = 1'b1;
      end
      OP_INC: begin
        add_a   = opnd;
        add_b   = '0;
        add_cin = 1'b1;
      end
      OP_DEC: begin
        add_a   = opnd;
        add_b   = '1;
        add_cin = 1'b0;
      end
      OP_CMP: begin
        add_b   = ~opnd;
        add_cin = 1'b1;
      end
      default: ;
    endcase
  end

  alu8_adder #(.WIDTH(WIDTH), .DECIMAL_EN(DECIMAL_EN)) u_adder (
    .add_a   (add_a),
    .add_b   (add_b),
    .add_cin (add_cin),
    .add_dec (add_dec),
    .add_sub (add_sub),
    .add_sum (add_sum),
    .add_cout(add_cout),
    .add_ovf (add_ovf)
  );

  // result selection
  always_comb begin
    if (is_logic)      result = lg_res;
    else if (is_shift) result = sh_res;
    else if (is_bit)   result = acc;
    else               result = add_sum;
  end

  // flags and write-enables
  assign flag_n = is_bit ? tst_n : result[WIDTH-1];
  assign flag_z = is_bit ? tst_z : (result == '0);
  assign flag_v = is_bit ? tst_v : add_ovf;
  assign flag_c = is_shift ? sh_cout : add_cout;

  assign res_we = known_op & ~is_bit & ~is_cmp;
  assign we_n   = known_op;
  assign we_z   = known_op;
  assign we_v   = is_bit | is_arith;
  assign we_c   = is_shift | is_arith | is_cmp;

endmodule

// File: rtl/alu8_dec_chk.sv
module alu8_dec_chk
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic [OP_W-1:0]  op,
  input logic [WIDTH-1:0] acc,
  input logic [WIDTH-1:0] opnd,
  input logic             carry_in,
  input logic             dec_mode,
  input logic [WIDTH-1:0] result,
  input logic             res_we,
  input logic             flag_n,
  input logic             flag_v,
  input logic             flag_z,
  input logic             flag_c,
  input logic             we_n,
  input logic             we_v,
  input logic             we_z,
  input logic             we_c
);

  always_comb begin
    if (op == OP_BIT) begin
      // R2
      bit_test_chk: assert (!res_we && !we_c && we_v && flag_v == opnd[WIDTH-2] &&
                            flag_n == opnd[WIDTH-1] && flag_z == ((acc & opnd) == '0));
    end
    if (op == OP_ASL) begin
      // R3
      asl_carry_chk: assert (flag_c == opnd[WIDTH-1] && result[0] == 1'b0);
    end
    if (op == OP_LSR) begin
      // R3
      lsr_carry_chk: assert (flag_c == opnd[0] && result[WIDTH-1] == 1'b0);
    end
    if (op == OP_ADC && !dec_mode) begin
      // R5
      add_ovf_chk: assert (flag_v == ((acc[WIDTH-1] == opnd[WIDTH-1]) &&
                                      (result[WIDTH-1] != acc[WIDTH-1])));
    end
    if (op == OP_CMP) begin
      // R10
      cmp_chk: assert (!res_we && !we_v && we_c && flag_c == (acc >= opnd));
    end
    if ((we_n || we_z) && op != OP_BIT) begin
      // R11
      nz_follow_chk: assert (flag_n == result[WIDTH-1] && flag_z == (result == '0));
    end
    if (op > OP_CMP) begin
      // R12
      no_write_chk: assert (!res_we && !we_n && !we_v && !we_z && !we_c);
    end
  end

endmodule

bind alu8_dec alu8_dec_chk #(.WIDTH(WIDTH)) u_chk (
  .op      (op),
  .acc     (acc),
  .opnd    (opnd),
  .carry_in(carry_in),
  .dec_mode(dec_mode),
  .result  (result),
  .res_we  (res_we),
  .flag_n  (flag_n),
  .flag_v  (flag_v),
  .flag_z  (flag_z),
  .flag_c  (flag_c),
  .we_n    (we_n),
  .we_v    (we_v),
  .we_z    (we_z),
  .we_c    (we_c)
);

// File: tb/sim_alu8_dec.sv
module sim_alu8_dec;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op = '0;
  logic [7:0] acc = '0, opnd = '0;
  logic       carry_in = 1'b0, dec_mode = 1'b0;
  logic [7:0] result;
  logic       res_we, flag_n, flag_v, flag_z, flag_c, we_n, we_v, we_z, we_c;

  always #10 clk = ~clk;   // 50 MHz

  alu8_dec u0 (
    .op(op), .acc(acc), .opnd(opnd), .carry_in(carry_in), .dec_mode(dec_mode),
    .result(result), .res_we(res_we),
    .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
    .we_n(we_n), .we_v(we_v), .we_z(we_z), .we_c(we_c)
  );

  typedef struct {
    logic [7:0] res;
    logic       rwe;
    logic [3:0] we;    // {n,v,z,c}
    logic [3:0] fl;    // {n,v,z,c}
    int         req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  function automatic int bcd2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  // independent reference built from the requirements
  function automatic exp_t model(input logic [3:0] o, input logic [7:0] a, m,
                                 input logic ci, d, input int req);
    exp_t e;
    logic [8:0] w;
    logic [7:0] nb;
    int         t;
    e.res = 8'h00; e.rwe = 1'b1; e.we = 4'b1010; e.fl = 4'b0000; e.req = req;
    case (o)
      4'd0: e.res = a & m;
      4'd1: e.res = a ^ m;
      4'd2: e.res = a | m;
      4'd3: begin
        e.rwe = 1'b0; e.we = 4'b1110;
        e.fl = {m[7], m[6], (a & m) == 8'h00, 1'b0};
      end
      4'd4: begin e.res = {m[6:0], 1'b0}; e.we = 4'b1011; e.fl[0] = m[7]; end
      4'd5: begin e.res = {1'b0, m[7:1]}; e.we = 4'b1011; e.fl[0] = m[0]; end
      4'd6: begin e.res = {m[6:0], ci};   e.we = 4'b1011; e.fl[0] = m[7]; end
      4'd7: begin e.res = {ci, m[7:1]};   e.we = 4'b1011; e.fl[0] = m[0]; end
      4'd8, 4'd9: begin
        nb = (o == 4'd9) ? ~m : m;
        w  = {1'b0, a} + {1'b0, nb} + {8'h00, ci};
        e.we = 4'b1111;
        e.fl[2] = (a[7] == nb[7]) && (w[7] != a[7]);
        if (!d) begin
          e.res = w[7:0]; e.fl[0] = w[8];
        end else if (o == 4'd8) begin
          t = bcd2i(a) + bcd2i(m) + int'(ci);
          e.fl[0] = (t >= 100); e.res = i2bcd(t % 100);
        end else begin
          t = bcd2i(a) - bcd2i(m) - (ci ? 0 : 1);
          e.fl[0] = (t >= 0); e.res = i2bcd((t + 100) % 100);
        end
      end
      4'd10: e.res = m + 8'd1;
      4'd11: e.res = m - 8'd1;
      4'd12: begin
        e.res = a - m; e.rwe = 1'b0; e.we = 4'b1011; e.fl[0] = (a >= m);
      end
      default: begin e.rwe = 1'b0; e.we = 4'b0000; end
    endcase
    if (o != 4'd3) begin
      e.fl[3] = e.res[7];
      e.fl[1] = (e.res == 8'h00);
    end
    return e;
  endfunction

  // driver: apply one vector just after a rising edge, queue its expectation
  task automatic apply(input logic [3:0] o, input logic [7:0] a, m,
                       input logic ci, d, input int req);
    @(posedge clk);
    #2;
    op = o; acc = a; opnd = m; carry_in = ci; dec_mode = d;
    q.push_back(model(o, a, m, ci, d, req));
  endtask

  // monitor: results are combinational, compare half a period later
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [3:0] got_fl, msk;
      bit bad;
      e = q.pop_front();
      got_fl = {flag_n, flag_v, flag_z, flag_c};
      msk = e.we;
      bad = (res_we !== e.rwe) || ({we_n, we_v, we_z, we_c} !== e.we) ||
            ((got_fl & msk) !== (e.fl & msk)) || (e.rwe && result !== e.res);
      n_chk++;
      if (bad) begin
        n_fail++;
        $display("FAIL R%0d op=%0d a=%h m=%h ci=%b d=%b: got res=%h rwe=%b we=%b fl=%b, exp res=%h rwe=%b we=%b fl=%b",
                 e.req, op, acc, opnd, carry_in, dec_mode,
                 result, res_we, {we_n, we_v, we_z, we_c}, got_fl,
                 e.res, e.rwe, e.we, e.fl & msk);
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // initial state: all-zero inputs give a zero AND result (R11)
    apply(4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 11);
    // R1 bitwise ops
    apply(4'd0, 8'hF0, 8'h3C, 1'b1, 1'b0, 1);
    apply(4'd1, 8'hF0, 8'h3C, 1'b0, 1'b0, 1);
    apply(4'd2, 8'h80, 8'h01, 1'b0, 1'b1, 1);
    // R2 bit test
    apply(4'd3, 8'h0F, 8'hC0, 1'b1, 1'b0, 2);
    apply(4'd3, 8'hFF, 8'h41, 1'b0, 1'b0, 2);
    // R3 shifts
    apply(4'd4, 8'h00, 8'h81, 1'b1, 1'b0, 3);
    apply(4'd5, 8'h00, 8'h01, 1'b1, 1'b0, 3);
    // R4 rotates
    apply(4'd6, 8'h00, 8'h40, 1'b1, 1'b0, 4);
    apply(4'd7, 8'h00, 8'h02, 1'b1, 1'b0, 4);
    // R5 binary add, signed overflow both ways
    apply(4'd8, 8'h7F, 8'h01, 1'b0, 1'b0, 5);
    apply(4'd8, 8'h80, 8'hFF, 1'b0, 1'b0, 5);
    apply(4'd8, 8'hFF, 8'h00, 1'b1, 1'b0, 5);
    // R6 binary subtract
    apply(4'd9, 8'h00, 8'h01, 1'b1, 1'b0, 6);
    apply(4'd9, 8'h80, 8'h01, 1'b1, 1'b0, 6);
    apply(4'd9, 8'h05, 8'h05, 1'b0, 1'b0, 6);
    // R7 decimal add
    apply(4'd8, 8'h09, 8'h01, 1'b0, 1'b1, 7);
    apply(4'd8, 8'h99, 8'h01, 1'b0, 1'b1, 7);
    apply(4'd8, 8'h58, 8'h46, 1'b1, 1'b1, 7);
    // R8 decimal subtract
    apply(4'd9, 8'h10, 8'h01, 1'b1, 1'b1, 8);
    apply(4'd9, 8'h00, 8'h01, 1'b1, 1'b1, 8);
    apply(4'd9, 8'h46, 8'h12, 1'b0, 1'b1, 8);
    // R9 increment / decrement wrap, binary in decimal mode
    apply(4'd10, 8'h00, 8'hFF, 1'b0, 1'b0, 9);
    apply(4'd10, 8'h00, 8'h09, 1'b0, 1'b1, 9);
    apply(4'd11, 8'h00, 8'h00, 1'b1, 1'b0, 9);
    // R10 compare
    apply(4'd12, 8'h40, 8'h40, 1'b0, 1'b1, 10);
    apply(4'd12, 8'h10, 8'h20, 1'b0, 1'b0, 10);
    apply(4'd12, 8'hFF, 8'h00, 1'b0, 1'b0, 10);
    // R12 undefined codes
    apply(4'd13, 8'h12, 8'h34, 1'b1, 1'b0, 12);
    apply(4'd15, 8'h00, 8'h00, 1'b0, 1'b1, 12);
    // R11 sweep over all codes, binary mode
    for (int i = 0; i < 400; i++)
      apply(4'($urandom_range(15, 0)), 8'($urandom), 8'($urandom),
            1'($urandom), 1'b0, 11);
    // R7 / R8 sweep on valid BCD operands
    for (int i = 0; i < 300; i++)
      apply((i % 2 == 0) ? 4'd8 : 4'd9,
            i2bcd(int'($urandom_range(99, 0))), i2bcd(int'($urandom_range(99, 0))),
            1'($urandom), 1'b1, (i % 2 == 0) ? 7 : 8);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule